// File: doc/BRIEF.md
# Multi-Mode System Clock Selector

This block derives the machine clock of a small controller from two free-running oscillator inputs: a fast main oscillator and a slow sub oscillator. A two-bit mode value picks one of four rates. Three rates come from the main oscillator: divide by eight, divide by two, or undivided. The fourth rate is the sub oscillator divided by two. The machine clock is built by gating each source with an enable that changes only while that source is low, so every pulse on the output is a whole source pulse.

Software writes the mode, a main-oscillator stop request and a sub-oscillator drive-strength bit through a single write strobe. The write is taken on the machine clock. A new mode is not applied at once. The previous rate stays in force for a fixed number of machine cycles that depends on the target mode, and then the new rate takes over. When the source changes, the old source is switched off before the new one is switched on, and each side confirms the change through its own two-flop synchronizer. A request that cannot be served yet is held and reported. The main-oscillator stop is accepted only while the sub oscillator is the one driving the machine clock.

Top module: `sysclk_sel`

## Requirements
- R1: After reset the mode in effect is middle (code 00), `main_osc_en` is 1, `sub_drive_hi` is 1, `mode_held` is 0, and the machine clock period is eight main periods.
- R2: The machine clock period is eight main periods in middle mode (00), one main period in double mode (01), two main periods in high mode (10), and two sub periods in low mode (11).
- R3: The write edge of a mode request counts as edge 0. `mode_eff` takes the requested value on machine clock edge 8 for double, edge 4 for high or low, and edge 1 for middle. Until that edge the machine clock keeps the period of the previous mode.
- R4: When `wr_main_stop` is written as 1, the stop is accepted only if the mode in effect is low and the sub branch drives the clock. An accepted stop drives `main_osc_en` to 0 from the write edge. Otherwise the write leaves `main_osc_en` unchanged.
- R5: Writing `wr_main_stop` as 0 sets `main_osc_en` back to 1 from the write edge.
- R6: `sub_drive_hi` takes `wr_sub_drive` on a write. A cycle with `stop_evt` high forces it to 1, even when a write of 0 happens in the same cycle.
- R7: A request for a main-derived mode is held while the main oscillator is stopped or `main_stable` is low. While it is held, `mode_held` is 1 and the mode in effect stays the same. The request proceeds once both conditions clear.
- R8: A request for low mode is held while `sub_stable` is low, with `mode_held` at 1. It proceeds once the flag rises.
- R9: The main and sub branches are never enabled at the same time. A branch is switched off only while its own source is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main oscillator (fast) |
| clk_sub | input | 1 | Sub oscillator (slow) |
| rst_n | input | 1 | Active-low reset, taken synchronously in each domain |
| wr_en | input | 1 | Write strobe, sampled on the machine clock |
| wr_mode | input | 2 | Requested mode: 00 middle, 01 double, 10 high, 11 low |
| wr_main_stop | input | 1 | Main oscillator stop request |
| wr_sub_drive | input | 1 | Sub oscillator drive strength, 1 = strong |
| main_stable | input | 1 | Main oscillator reported stable |
| sub_stable | input | 1 | Sub oscillator reported stable |
| stop_evt | input | 1 | Stop event, forces strong sub drive |
| clk_phi | output | 1 | Machine clock |
| mode_eff | output | 2 | Mode currently in effect |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_drive_hi | output | 1 | Sub oscillator drive strength |
| mode_held | output | 1 | A mode request is being held off |

## Verification
The bench builds the block with its default parameters: handover delays of 8, 4, 4 and 1 machine cycles, main divisors of 8 and 2, and a sub divisor of 2. It runs the main oscillator nine times faster than the sub oscillator. With only four modes, all twelve ordered mode transitions can be swept. For each one the bench measures the exact commit edge and the settled clock period, including the gap in which neither source drives the clock during a source change. The bench also gates its own main oscillator with `main_osc_en`, so the stop, the restart and the stability hold-offs act on a clock that really stops.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
// Shared types for the system clock selector.
// Assumes the mode code is two bits wide and that the lowest code is the reset mode.
package clksel_pkg;

    typedef enum logic [1:0] {
        MODE_MID  = 2'b00,
        MODE_DBL  = 2'b01,
        MODE_HIGH = 2'b10,
        MODE_LOW  = 2'b11
    } clk_mode_e;

    localparam int NUM_SRC = 2;   // branch 0 = main, branch 1 = sub
    localparam int SRC_MAIN = 0;
    localparam int SRC_SUB  = 1;

endpackage

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
// Mode control for the clock selector, clocked by the machine clock it helps produce.
// It holds the written fields, decides whether a request may start, and counts the
// handover delay of the target mode before it commits the new mode.
// Assumes the stability flags and stop_evt are synchronous to the machine clock.
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int LAT_DBL  = 8,
    parameter int LAT_HIGH = 4,
    parameter int LAT_LOW  = 4,
    parameter int LAT_MID  = 1,
    parameter int CW       = 4
) (
    input  logic       clk_phi,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       wr_main_stop,
    input  logic       wr_sub_drive,
    input  logic       main_stable,
    input  logic       sub_stable,
    input  logic       stop_evt,
    input  logic       sub_on,
    output clk_mode_e  mode_cur,
    output logic       main_stop,
    output logic       sub_drive,
    output logic       held
);

    clk_mode_e         req_q;
    clk_mode_e         req_nx;
    clk_mode_e         tgt_q;
    logic [CW-1:0]     cnt_q;
    logic              allowed;
    logic              stop_ok;

    // Delay in machine cycles before a request for mode m commits.
    function automatic logic [CW-1:0] lat_of(input clk_mode_e m);
        case (m)
            MODE_DBL:  lat_of = CW'(LAT_DBL);
            MODE_HIGH: lat_of = CW'(LAT_HIGH);
            MODE_LOW:  lat_of = CW'(LAT_LOW);
            default:   lat_of = CW'(LAT_MID);
        endcase
    endfunction

    // Pick the request seen this edge and decide whether it may start.
    always_comb begin
        req_nx  = wr_en ? clk_mode_e'(wr_mode) : req_q;
        allowed = (req_nx == MODE_LOW) ? sub_stable : (!main_stop && main_stable);
        stop_ok = (mode_cur == MODE_LOW) && sub_on;
    end

    // Hold the written fields: request, main stop and sub drive strength.
    always_ff @(posedge clk_phi) begin
        if (!rst_n) begin
            req_q     <= MODE_MID;
            main_stop <= 1'b0;
            sub_drive <= 1'b1;
        end else begin
            req_q <= req_nx;
            if (wr_en) begin
                main_stop <= wr_main_stop ? (main_stop | stop_ok) : 1'b0;
            end
            if (stop_evt) begin
                sub_drive <= 1'b1;
            end else if (wr_en) begin
                sub_drive <= wr_sub_drive;
            end
        end
    end

    // Count the handover delay, commit the target, and flag held requests.
    always_ff @(posedge clk_phi) begin
        if (!rst_n) begin
            mode_cur <= MODE_MID;
            tgt_q    <= MODE_MID;
            cnt_q    <= '0;
            held     <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
            held  <= 1'b0;
            if (cnt_q == CW'(1)) begin
                mode_cur <= tgt_q;
            end
        end else if (req_nx != mode_cur) begin
            if (allowed) begin
                cnt_q <= lat_of(req_nx);
                tgt_q <= req_nx;
                held  <= 1'b0;
            end else begin
                held  <= 1'b1;
            end
        end else begin
            held <= 1'b0;
        end
    end

endmodule

// File: rtl/clksel_branch.sv
`timescale 1ns/1ps
// One source branch of the glitch-free selector. A two-flop synchronizer in the
// branch's own domain takes the select, qualified by the other branch being off.
// On the falling edge of the source the branch updates its enable and divider,
// so the gated output only ever carries whole source pulses. A new ratio is
// loaded only when the running count wraps, so the old period always completes.
// Assumes the ratio input is at least 1 and changes well away from falling edges.
module clksel_branch #(
    parameter int CW     = 4,
    parameter bit RST_ON = 1'b0
) (
    input  logic          clk_src,
    input  logic          rst_n,
    input  logic          want,
    input  logic          other_on,
    input  logic [CW-1:0] ratio,
    output logic          on,
    output logic          clk_g
);

    logic          sync1;
    logic          sync2;
    logic          en_q;
    logic [CW-1:0] cnt_q;

    // Bring the qualified select into this source's domain.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            sync1 <= RST_ON;
            sync2 <= RST_ON;
        end else begin
            sync1 <= want && !other_on;
            sync2 <= sync1;
        end
    end

    // While the source is low, update the active flag, the divider count and the gate enable.
    always_ff @(negedge clk_src) begin
        if (!rst_n) begin
            on    <= RST_ON;
            en_q  <= RST_ON;
            cnt_q <= '0;
        end else begin
            on <= sync2;
            if (!sync2) begin
                en_q  <= 1'b0;
                cnt_q <= '0;
            end else if (cnt_q == '0) begin
                en_q  <= 1'b1;
                cnt_q <= ratio - CW'(1);
            end else begin
                en_q  <= 1'b0;
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign clk_g = clk_src & en_q;

endmodule

// File: rtl/sysclk_sel.sv
`timescale 1ns/1ps
// System clock selector top. It builds the machine clock from a main branch
// (divide by MID_DIV, HIGH_DIV or 1) and a sub branch (divide by SUB_DIV). The
// two branches hand over through cross-coupled synchronizers.
// Assumes the main oscillator is well above three times the sub rate, and that
// the main oscillator really stops when main_osc_en is low.
module sysclk_sel
    import clksel_pkg::*;
#(
    parameter int LAT_DBL  = 8,
    parameter int LAT_HIGH = 4,
    parameter int LAT_LOW  = 4,
    parameter int LAT_MID  = 1,
    parameter int MID_DIV  = 8,
    parameter int HIGH_DIV = 2,
    parameter int SUB_DIV  = 2
) (
    input  logic       clk_main,
    input  logic       clk_sub,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       wr_main_stop,
    input  logic       wr_sub_drive,
    input  logic       main_stable,
    input  logic       sub_stable,
    input  logic       stop_evt,
    output logic       clk_phi,
    output logic [1:0] mode_eff,
    output logic       main_osc_en,
    output logic       sub_drive_hi,
    output logic       mode_held
);

    localparam int LAT_MAX_A = (LAT_DBL > LAT_HIGH) ? LAT_DBL : LAT_HIGH;
    localparam int LAT_MAX_B = (LAT_LOW > LAT_MID) ? LAT_LOW : LAT_MID;
    localparam int LAT_MAX   = (LAT_MAX_A > LAT_MAX_B) ? LAT_MAX_A : LAT_MAX_B;
    localparam int LCW       = $clog2(LAT_MAX + 1);
    localparam int DIV_MAX_A = (MID_DIV > HIGH_DIV) ? MID_DIV : HIGH_DIV;
    localparam int DIV_MAX   = (DIV_MAX_A > SUB_DIV) ? DIV_MAX_A : SUB_DIV;
    localparam int DCW       = $clog2(DIV_MAX + 1);

    clk_mode_e            mode_cur;
    logic                 main_stop;
    logic [NUM_SRC-1:0]   src_clk;
    logic [NUM_SRC-1:0]   src_want;
    logic [NUM_SRC-1:0]   src_on;
    logic [NUM_SRC-1:0]   src_gclk;
    logic [DCW-1:0]       src_ratio [NUM_SRC];
    logic                 main_on;
    logic                 sub_on;

    clksel_ctrl #(
        .LAT_DBL  (LAT_DBL),
        .LAT_HIGH (LAT_HIGH),
        .LAT_LOW  (LAT_LOW),
        .LAT_MID  (LAT_MID),
        .CW       (LCW)
    ) u_ctrl (
        .clk_phi      (clk_phi),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_mode      (wr_mode),
        .wr_main_stop (wr_main_stop),
        .wr_sub_drive (wr_sub_drive),
        .main_stable  (main_stable),
        .sub_stable   (sub_stable),
        .stop_evt     (stop_evt),
        .sub_on       (sub_on),
        .mode_cur     (mode_cur),
        .main_stop    (main_stop),
        .sub_drive    (sub_drive_hi),
        .held         (mode_held)
    );

    // Route the sources, selects and divide ratios to the two branches.
    always_comb begin
        src_clk[SRC_MAIN]   = clk_main;
        src_clk[SRC_SUB]    = clk_sub;
        src_want[SRC_MAIN]  = (mode_cur != MODE_LOW);
        src_want[SRC_SUB]   = (mode_cur == MODE_LOW);
        src_ratio[SRC_SUB]  = DCW'(SUB_DIV);
        case (mode_cur)
            MODE_DBL:  src_ratio[SRC_MAIN] = DCW'(1);
            MODE_HIGH: src_ratio[SRC_MAIN] = DCW'(HIGH_DIV);
            default:   src_ratio[SRC_MAIN] = DCW'(MID_DIV);
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_branch
            clksel_branch #(
                .CW     (DCW),
                .RST_ON (g == SRC_MAIN)
            ) u_branch (
                .clk_src  (src_clk[g]),
                .rst_n    (rst_n),
                .want     (src_want[g]),
                .other_on (src_on[NUM_SRC-1-g]),
                .ratio    (src_ratio[g]),
                .on       (src_on[g]),
                .clk_g    (src_gclk[g])
            );
        end
    endgenerate

    assign main_on     = src_on[SRC_MAIN];
    assign sub_on      = src_on[SRC_SUB];
    assign clk_phi     = |src_gclk;
    assign mode_eff    = mode_cur;
    assign main_osc_en = !main_stop;

endmodule

// File: rtl/sysclk_sel_chk.sv
`timescale 1ns/1ps
// Assertion checker for the system clock selector, attached with bind.
// Assumes rst_n is held low for several main cycles at start.
module sysclk_sel_chk
    import clksel_pkg::*;
(
    input logic       clk_phi,
    input logic       clk_sub,
    input logic       rst_n,
    input logic       stop_evt,
    input logic [1:0] mode_eff,
    input logic       main_osc_en,
    input logic       sub_drive_hi,
    input logic       mode_held,
    input logic       main_on,
    input logic       sub_on
);

    // R4: the main oscillator is only ever off in low mode.
    p_stop_only_low_r4: assert property (@(posedge clk_phi) disable iff (!rst_n)
        !main_osc_en |-> (mode_eff == MODE_LOW));

    // R4: the main oscillator is only ever off while the sub branch drives the clock.
    p_stop_needs_sub_r4: assert property (@(posedge clk_phi) disable iff (!rst_n)
        !main_osc_en |-> sub_on);

    // R6: a stop event leaves strong sub drive behind it.
    p_stop_evt_drive_r6: assert property (@(posedge clk_phi) disable iff (!rst_n)
        stop_evt |=> sub_drive_hi);

    // R7: a held request does not move the mode on the next edge.
    p_held_freezes_r7: assert property (@(posedge clk_phi) disable iff (!rst_n)
        mode_held |=> $stable(mode_eff));

    // R9: the two branches are never active together.
    p_src_exclusive_r9: assert property (@(posedge clk_sub) disable iff (!rst_n)
        !(main_on && sub_on));

endmodule

bind sysclk_sel sysclk_sel_chk u_chk (
    .clk_phi      (clk_phi),
    .clk_sub      (clk_sub),
    .rst_n        (rst_n),
    .stop_evt     (stop_evt),
    .mode_eff     (mode_eff),
    .main_osc_en  (main_osc_en),
    .sub_drive_hi (sub_drive_hi),
    .mode_held    (mode_held),
    .main_on      (main_on),
    .sub_on       (sub_on)
);

// File: tb/sysclk_sel_test.sv
`timescale 1ns/1ps
// Bench for the system clock selector: sweeps every ordered mode transition and
// the stop, drive and hold-off cases. Main runs at 250 MHz, sub at 9x slower.
module sysclk_sel_test;

    localparam real T_MAIN = 4.0;
    localparam real T_SUB  = 36.0;

    logic       main_raw = 1'b0;
    logic       clk_sub  = 1'b0;
    logic       clk_main;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_mode = 2'b00;
    logic       wr_main_stop = 1'b0;
    logic       wr_sub_drive = 1'b1;
    logic       main_stable = 1'b1;
    logic       sub_stable = 1'b1;
    logic       stop_evt = 1'b0;
    logic       clk_phi;
    logic [1:0] mode_eff;
    logic       main_osc_en;
    logic       sub_drive_hi;
    logic       mode_held;

    int tests = 0;
    int fails = 0;

    always #2  main_raw = ~main_raw;
    always #18 clk_sub  = ~clk_sub;
    assign clk_main = main_raw & main_osc_en;

    sysclk_sel uut (
        .clk_main     (clk_main),
        .clk_sub      (clk_sub),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_mode      (wr_mode),
        .wr_main_stop (wr_main_stop),
        .wr_sub_drive (wr_sub_drive),
        .main_stable  (main_stable),
        .sub_stable   (sub_stable),
        .stop_evt     (stop_evt),
        .clk_phi      (clk_phi),
        .mode_eff     (mode_eff),
        .main_osc_en  (main_osc_en),
        .sub_drive_hi (sub_drive_hi),
        .mode_held    (mode_held)
    );

    function automatic int lat_of(input int m);
        case (m)
            1:       return 8;
            2:       return 4;
            3:       return 4;
            default: return 1;
        endcase
    endfunction

    function automatic real period_of(input int m);
        case (m)
            1:       return T_MAIN;
            2:       return 2.0 * T_MAIN;
            3:       return 2.0 * T_SUB;
            default: return 8.0 * T_MAIN;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input real act, input real exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
        end
    endtask

    task automatic do_write(input int m, input bit stp, input bit drv);
        @(negedge clk_phi);
        wr_en = 1'b1; wr_mode = 2'(m); wr_main_stop = stp; wr_sub_drive = drv;
        @(negedge clk_phi);
        wr_en = 1'b0;
    endtask

    task automatic wait_mode(input int m, input int lim, output int n);
        n = 0;
        while (mode_eff != 2'(m) && n < lim) begin
            @(negedge clk_phi);
            n++;
        end
    endtask

    task automatic settle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk_phi);
    endtask

    task automatic measure(output real p);
        real t1;
        @(posedge clk_phi); t1 = $realtime;
        @(posedge clk_phi); p = $realtime - t1;
    endtask

    task automatic goto_mode(input int m);
        int n;
        if (mode_eff != 2'(m)) begin
            do_write(m, 1'b0, 1'b1);
            wait_mode(m, 40, n);
        end
        settle(30);
    endtask

    initial begin
        real p;
        int  n;
        repeat (10) @(posedge main_raw);
        @(negedge main_raw);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk_phi);
        chk(mode_eff == 2'b00, "R1 mode", mode_eff, 0);
        chk(main_osc_en == 1'b1, "R1 osc_en", main_osc_en, 1);
        chk(sub_drive_hi == 1'b1, "R1 drive", sub_drive_hi, 1);
        chk(mode_held == 1'b0, "R1 held", mode_held, 0);
        measure(p);
        chk(p > 31.99 && p < 32.01, "R1 period", p, 32.0);

        // R3: old rate stays during the double-mode countdown
        do_write(1, 1'b0, 1'b1);
        measure(p);
        chk(p > 31.99 && p < 32.01, "R3 old period", p, 32.0);
        wait_mode(1, 40, n);
        settle(30);

        // R2, R3: all ordered transitions
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                if (f != t) begin
                    goto_mode(f);
                    do_write(t, 1'b0, 1'b1);
                    wait_mode(t, 40, n);
                    chk(n == lat_of(t), $sformatf("R3 latency %0d->%0d", f, t), n, lat_of(t));
                    settle(30);
                    measure(p);
                    chk(p > period_of(t) - 0.01 && p < period_of(t) + 0.01,
                        $sformatf("R2 period %0d->%0d", f, t), p, period_of(t));
                end
            end
        end

        // R4: stop ignored outside low mode
        goto_mode(0);
        do_write(0, 1'b1, 1'b1);
        chk(main_osc_en == 1'b1, "R4 stop ignored", main_osc_en, 1);

        // R8: low request held while sub unstable
        sub_stable = 1'b0;
        do_write(3, 1'b0, 1'b1);
        settle(20);
        chk(mode_eff == 2'b00, "R8 mode kept", mode_eff, 0);
        chk(mode_held == 1'b1, "R8 held", mode_held, 1);
        sub_stable = 1'b1;
        wait_mode(3, 40, n);
        chk(mode_eff == 2'b11, "R8 proceeds", mode_eff, 3);
        settle(30);

        // R4: stop accepted in low mode
        do_write(3, 1'b1, 1'b1);
        chk(main_osc_en == 1'b0, "R4 stop taken", main_osc_en, 0);
        main_stable = 1'b0;

        // R7: main request held while stopped
        do_write(0, 1'b1, 1'b1);
        settle(20);
        chk(mode_eff == 2'b11, "R7 mode kept stopped", mode_eff, 3);
        chk(mode_held == 1'b1, "R7 held stopped", mode_held, 1);

        // R5: clearing the stop restarts the main oscillator
        do_write(0, 1'b0, 1'b1);
        chk(main_osc_en == 1'b1, "R5 restart", main_osc_en, 1);

        // R7: still held until stable
        settle(10);
        chk(mode_eff == 2'b11, "R7 mode kept unstable", mode_eff, 3);
        chk(mode_held == 1'b1, "R7 held unstable", mode_held, 1);
        main_stable = 1'b1;
        wait_mode(0, 40, n);
        chk(mode_eff == 2'b00, "R7 proceeds", mode_eff, 0);
        settle(30);
        chk(mode_held == 1'b0, "R7 held cleared", mode_held, 0);
        measure(p);
        chk(p > 31.99 && p < 32.01, "R7 period after restart", p, 32.0);

        // R6: drive strength write and stop event
        do_write(0, 1'b0, 1'b0);
        chk(sub_drive_hi == 1'b0, "R6 drive written", sub_drive_hi, 0);
        @(negedge clk_phi); stop_evt = 1'b1;
        @(negedge clk_phi); stop_evt = 1'b0;
        chk(sub_drive_hi == 1'b1, "R6 stop_evt sets", sub_drive_hi, 1);
        do_write(0, 1'b0, 1'b0);
        @(negedge clk_phi);
        wr_en = 1'b1; wr_mode = 2'b00; wr_sub_drive = 1'b0; stop_evt = 1'b1;
        @(negedge clk_phi);
        wr_en = 1'b0; stop_evt = 1'b0;
        chk(sub_drive_hi == 1'b1, "R6 stop_evt wins", sub_drive_hi, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #800000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule